// File: doc/BRIEF.md
# Tagged-Word Operand-Select Adder

This block is the arithmetic unit of an 8-bit datapath in which the top bit of each word is a tag and the lower seven bits hold the value. A two-bit selector picks the first operand from four fixed sources: zero, a narrow argument counter, the constant -2, or a stack/index register. The second operand is the value register itself or a masked form of it that keeps only its two low bits and forces every other bit to one. A carry input completes the sum. With selector and carry set suitably, the same adder produces the value unchanged, plus one, minus one or minus two.

The block drives three results. The first is the full 8-bit sum, used when binding arguments. The second is a write-back word that takes its seven low bits from the sum and its tag bit from the incoming value register, so that incrementing or decrementing a constant never changes its tag. The third is the carry out of bit 7. All three are captured in an output register that loads when enable is high and clears on a synchronous reset.

Top module: `tagged_adder`

## Requirements
- R1: With `sel` = 2'b00 the first operand is 8'h00 and the second operand is `v`, so `sum_full` = `v` + `cin`.
- R2: With `sel` = 2'b01 the first operand is `acc` zero-extended to 8 bits, and the second operand is {6'b111111, v[1:0]}.
- R3: With `sel` = 2'b10 the first operand is 8'hFE (-2) and the second operand is `v`, giving `v`-2 when `cin`=0 and `v`-1 when `cin`=1 (modulo 256).
- R4: With `sel` = 2'b11 the first operand is `si` and the second operand is {6'b111111, v[1:0]}.
- R5: `sum_full` is (A + B + `cin`) modulo 256 and `carry_out` is bit 8 of that sum, for every selector and carry value, including `sel` = 2'b01 or 2'b11 with `cin` = 1.
- R6: `bus_word[6:0]` equals the sum's bits [6:0] and `bus_word[7]` equals `v[7]`, whatever the sum's bit 7 is.
- R7: `sum_full` carries all eight sum bits, bit 7 included, without tag substitution.
- R8: When `rst` is high at a rising edge of `clk`, all outputs are zero after that edge, whatever `en` is.
- R9: When `en` is high (and `rst` low) at a rising edge, the outputs take the result for the inputs at that edge; when `en` is low they keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| en | input | 1 | Load enable for the output register |
| sel | input | 2 | Operand selector (00 zero, 01 counter, 10 minus two, 11 stack/index) |
| cin | input | 1 | Carry input to the addition |
| v | input | 8 | Value register; bit 7 is the tag |
| acc | input | 4 | Argument counter, zero-extended when selected |
| si | input | 8 | Stack/index register |
| sum_full | output | 8 | Registered full sum for binding |
| bus_word | output | 8 | Registered write-back word, tag bit from v[7] |
| carry_out | output | 1 | Registered carry out of bit 7 |

## Verification
On every cycle, assertions check that the write-back word's tag equals the value register's tag from the load cycle, that its low seven bits agree with the full sum, that the identity and decrement selector settings return the value and the value minus one, and that the register clears on reset and holds without enable. Only the bench's sweep can show the complete arithmetic for every selector, carry and value, the masking of the second operand, the zero extension of the counter and the unused selector/carry combinations, since it compares each output against an independently computed sum over all 256 values with random counter and stack/index words.

// File: rtl/tagadd_pkg.sv
package tagadd_pkg;
    localparam int TA_DATA_W = 8;
    localparam int TA_ACC_W  = 4;
    localparam int TA_KEEP_W = 2;

    typedef enum logic [1:0] {
        SRC_ZERO  = 2'b00,
        SRC_COUNT = 2'b01,
        SRC_MTWO  = 2'b10,
        SRC_STACK = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic                 cout;
        logic [TA_DATA_W-1:0] full;
        logic [TA_DATA_W-1:0] bus;
    } add_res_t;
endpackage

// File: rtl/tag_opnd_sel.sv
module tag_opnd_sel
    import tagadd_pkg::*;
#(
    parameter int DATA_W = TA_DATA_W,
    parameter int ACC_W  = TA_ACC_W,
    parameter int KEEP_W = TA_KEEP_W
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] v,
    input  logic [ACC_W-1:0]  acc,
    input  logic [DATA_W-1:0] si,
    output logic [DATA_W-1:0] opa,
    output logic [DATA_W-1:0] opb
);
    localparam logic [DATA_W-1:0] MINUS_TWO = {{(DATA_W-1){1'b1}}, 1'b0};
    localparam int                FILL_W    = DATA_W - KEEP_W;

    logic [DATA_W-1:0] v_masked;

    assign v_masked = {{FILL_W{1'b1}}, v[KEEP_W-1:0]};

    always_comb begin
        unique case (src_sel_e'(sel))
            SRC_ZERO:  opa = '0;
            SRC_COUNT: opa = {{(DATA_W-ACC_W){1'b0}}, acc};
            SRC_MTWO:  opa = MINUS_TWO;
            default:   opa = si;
        endcase
        // odd selectors (counter, stack) pair with the masked value
        opb = sel[0] ? v_masked : v;
    end
endmodule

// File: rtl/tag_ripple_add.sv
module tag_ripple_add #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout
);
    logic [DATA_W:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b[i] ^ chain[i];
        assign chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
    end

    assign cout = chain[DATA_W];
endmodule

// File: rtl/tag_out_stage.sv
module tag_out_stage
    import tagadd_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  add_res_t res_in,
    output add_res_t res_out
);
    if (OUT_REG) begin : g_reg
        add_res_t res_d, res_q;

        always_comb begin
            res_d = res_q;
            if (rst)
                res_d = '0;
            else if (en)
                res_d = res_in;
        end

        always_ff @(posedge clk) begin
            res_q <= res_d;
        end

        assign res_out = res_q;

        // R8: reset clears everything
        a_r8_reset_zero: assert property (@(posedge clk)
            rst |=> (res_q == '0));

        // R9: no enable, no change
        a_r9_hold: assert property (@(posedge clk) disable iff (rst)
            !en |=> $stable(res_q));

        // R6: low bits of bus word agree with the full sum
        a_r6_bus_low: assert property (@(posedge clk) disable iff (rst)
            en |=> (res_q.bus[TA_DATA_W-2:0] == res_q.full[TA_DATA_W-2:0]));
    end else begin : g_pass
        assign res_out = res_in;
    end
endmodule

// File: rtl/tagged_adder.sv
module tagged_adder
    import tagadd_pkg::*;
#(
    parameter int DATA_W  = TA_DATA_W,
    parameter int ACC_W   = TA_ACC_W,
    parameter int KEEP_W  = TA_KEEP_W,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [1:0]        sel,
    input  logic              cin,
    input  logic [DATA_W-1:0] v,
    input  logic [ACC_W-1:0]  acc,
    input  logic [DATA_W-1:0] si,
    output logic [DATA_W-1:0] sum_full,
    output logic [DATA_W-1:0] bus_word,
    output logic              carry_out
);
    localparam int TAG_BIT = DATA_W - 1;

    logic [DATA_W-1:0] opa, opb, raw_sum;
    logic              raw_cout;
    add_res_t          res_d, res_q;

    tag_opnd_sel #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W),
        .KEEP_W (KEEP_W)
    ) u_sel (
        .sel (sel),
        .v   (v),
        .acc (acc),
        .si  (si),
        .opa (opa),
        .opb (opb)
    );

    tag_ripple_add #(
        .DATA_W (DATA_W)
    ) u_add (
        .a    (opa),
        .b    (opb),
        .cin  (cin),
        .sum  (raw_sum),
        .cout (raw_cout)
    );

    always_comb begin
        res_d.cout = raw_cout;
        res_d.full = raw_sum;
        // tag comes from the value register, not the sum
        res_d.bus  = {v[TAG_BIT], raw_sum[TAG_BIT-1:0]};
    end

    tag_out_stage #(
        .OUT_REG (OUT_REG)
    ) u_out (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .res_in  (res_d),
        .res_out (res_q)
    );

    assign sum_full  = res_q.full;
    assign bus_word  = res_q.bus;
    assign carry_out = res_q.cout;

    if (OUT_REG) begin : g_chk
        // R6: tag bit follows v[7] of the load cycle
        a_r6_tag_kept: assert property (@(posedge clk) disable iff (rst)
            en |=> (bus_word[TAG_BIT] == $past(v[TAG_BIT])));

        // R1: zero selector without carry copies the value
        a_r1_identity: assert property (@(posedge clk) disable iff (rst)
            (en && sel == 2'b00 && !cin) |=> (sum_full == $past(v)));

        // R3: minus-two selector with carry decrements
        a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
            (en && sel == 2'b10 && cin) |=> (sum_full == $past(v) - 1'b1));
    end
endmodule

// File: tb/tagged_adder_test.sv
module tagged_adder_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       cin = 1'b0;
    logic [7:0] v   = 8'h00;
    logic [3:0] acc = 4'h0;
    logic [7:0] si  = 8'h00;
    logic [7:0] sum_full, bus_word;
    logic       carry_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    tagged_adder uut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .sel       (sel),
        .cin       (cin),
        .v         (v),
        .acc       (acc),
        .si        (si),
        .sum_full  (sum_full),
        .bus_word  (bus_word),
        .carry_out (carry_out)
    );

    function automatic logic [8:0] ref_sum(input logic [1:0] s, input logic c,
                                           input logic [7:0] vv, input logic [3:0] aa,
                                           input logic [7:0] ss);
        logic [7:0] a, b;
        case (s)
            2'b00: a = 8'h00;
            2'b01: a = {4'h0, aa};
            2'b10: a = 8'hFE;
            default: a = ss;
        endcase
        b = s[0] ? {6'b111111, vv[1:0]} : vv;
        return {1'b0, a} + {1'b0, b} + {8'h00, c};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic e, input logic [1:0] s, input logic c,
                         input logic [7:0] vv, input logic [3:0] aa, input logic [7:0] ss);
        @(negedge clk);
        en = e; sel = s; cin = c; v = vv; acc = aa; si = ss;
        @(negedge clk);
    endtask

    task automatic check_vec(input string req, input logic [1:0] s, input logic c,
                             input logic [7:0] vv, input logic [3:0] aa, input logic [7:0] ss);
        logic [8:0] r;
        r = ref_sum(s, c, vv, aa, ss);
        apply(1'b1, s, c, vv, aa, ss);
        check({req, " sum_full"}, sum_full, r[7:0]);
        check("R6 bus_word", bus_word, {vv[7], r[6:0]});
        check("R5 carry_out", carry_out, r[8]);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (2) @(negedge clk);
        // R8: reset state
        check("R8 reset sum", sum_full, 8'h00);
        check("R8 reset bus", bus_word, 8'h00);
        check("R8 reset cout", carry_out, 1'b0);
        rst = 1'b0;

        // directed corners
        check_vec("R1 identity", 2'b00, 1'b0, 8'h85, 4'h0, 8'h00);
        check_vec("R1 increment", 2'b00, 1'b1, 8'h7F, 4'h0, 8'h00);   // tag 0 kept, sum bit7 1
        check_vec("R3 minus two", 2'b10, 1'b0, 8'h00, 4'h0, 8'h00);
        check_vec("R3 decrement", 2'b10, 1'b1, 8'h80, 4'h0, 8'h00);   // tag 1 kept
        check_vec("R2 counter", 2'b01, 1'b0, 8'hFF, 4'hF, 8'h00);
        check_vec("R4 stack", 2'b11, 1'b1, 8'h02, 4'h0, 8'hFF);       // unused combo
        check_vec("R7 full bit7", 2'b11, 1'b0, 8'h00, 4'h0, 8'h83);

        // sweep every selector, carry and value with random counter/stack
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 2; c++) begin
                for (int x = 0; x < 256; x++) begin
                    logic [3:0] aa;
                    logic [7:0] ss;
                    aa = 4'($urandom);
                    ss = 8'($urandom);
                    case (s)
                        0: check_vec("R1 sweep", 2'(s), 1'(c), 8'(x), aa, ss);
                        1: check_vec("R2 sweep", 2'(s), 1'(c), 8'(x), aa, ss);
                        2: check_vec("R3 sweep", 2'(s), 1'(c), 8'(x), aa, ss);
                        default: check_vec("R4 sweep", 2'(s), 1'(c), 8'(x), aa, ss);
                    endcase
                end
            end
        end

        // R9: hold without enable
        check_vec("R9 load", 2'b00, 1'b1, 8'h10, 4'h0, 8'h00);
        apply(1'b0, 2'b11, 1'b1, 8'hF3, 4'hA, 8'h77);
        check("R9 hold sum", sum_full, 8'h11);
        check("R9 hold bus", bus_word, 8'h11);
        check("R9 hold cout", carry_out, 1'b0);

        // R8: reset wins over enable
        check_vec("R5 carry set", 2'b11, 1'b1, 8'h03, 4'h0, 8'hFF);
        @(negedge clk);
        rst = 1'b1; en = 1'b1;
        @(negedge clk);
        check("R8 reset over en sum", sum_full, 8'h00);
        check("R8 reset over en bus", bus_word, 8'h00);
        check("R8 reset over en cout", carry_out, 1'b0);
        rst = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule